// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words on a half-duplex synchronous link while acting as the clock master. It generates a shift clock on its own output pin, samples a single data input from the far end, and assembles 8-bit or 9-bit words with the least significant bit arriving first. Software configures it through a small register port. Writes set the control bits and a two-byte clock divisor. Reads return the control state, a status register and the received data byte.

Reception runs in one of two ways. A one-shot enable fetches exactly one word, then turns itself off. A continuous enable fetches words back to back until software drops it. A completion flag, with an optional interrupt, reports each finished word. Reading the data register clears that flag. If a word completes before the previous one was read, an overrun error is raised and later words are thrown away until software clears the continuous enable.

Top module: `sync_master_rx`

## Requirements
- R1: After reset the control register (address 0), the divisor bytes (addresses 1 and 2), the status register (address 3) and the data register (address 4) all read 0. The shift clock output is low and the interrupt is low.
- R2: The shift clock toggles only while the synchronous-mode bit (control bit 0) is set and at least one of the one-shot enable (control bit 1) or the continuous enable (control bit 2) is set. Otherwise it stays at its idle level.
- R3: With only the one-shot enable set, exactly one word is received, giving one active clock edge per data bit. The block then clears control bit 1 itself and stops the clock.
- R4: With the continuous enable set, words are received back to back. Clearing it stops the clock at its idle level, and no further edges follow.
- R5: With both enables set, continuous reception takes precedence. Successive words are received, and control bit 1 stays set.
- R6: The data input is sampled at the falling edge of the non-inverted shift clock, and the first bit sampled is bit 0 of the word.
- R7: When the 9-bit mode (control bit 3) is set, the word's ninth bit is reported in status bit 2 and the low 8 bits in the data register. In 8-bit mode status bit 2 reads 0.
- R8: Control bit 4 inverts the clock output. The idle level of the output then equals that bit, and every active edge moves away from the idle level.
- R9: The shift clock period is 4 × (divisor + 1) system clocks. The divisor is {address 2, address 1} when control bit 5 is set; otherwise it is address 1 alone.
- R10: Status bit 0 (word ready) is set when a word completes. The interrupt output equals status bit 0 AND control bit 6. A read of address 4 with the read strobe clears status bit 0.
- R11: If a word completes while status bit 0 is still set, status bit 1 (overrun) is set and the data register keeps the unread word. While overrun is set, completed words are discarded. A control write that changes control bit 2 from 1 to 0 clears overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe (for read side effects) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rx_in | input | 1 | Serial data from the far end |
| sclk_out | output | 1 | Generated shift clock |
| irq | output | 1 | Receive interrupt |

## Verification
The bench uses a slave model that shifts out a fixed bit stream on each active clock edge, and it measures the spacing between those edges. This catches a divider that ignores the 8/16-bit select, leaks the high byte, or runs off by one count. It also catches bits assembled in reverse order. With both enables set, the bench confirms that more than one word arrives and that the one-shot bit survives. A design that let the one-shot enable win would stop after a single word. For overrun, the bench leaves a word unread across several word times. It then checks that the first word is still held, that later words never raise the ready flag again, and that only dropping the continuous enable clears the error. The bench also confirms that an inverted clock idles high, and that nothing clocks while synchronous mode is off.

// File: rtl/sync_mrx_pkg.sv
package sync_mrx_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd1;
   localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd2;
   localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA   = 3'd4;

   localparam int CB_SINGLE = 1;
   localparam int CB_CONT   = 2;
   localparam int CTRL_BITS = 7;

   // control fields, bit 0 (sync_mode) is the least significant
   typedef struct packed {
      logic irq_en;
      logic div16;
      logic invert;
      logic nine;
      logic cont;
      logic single;
      logic sync_mode;
   } ctrl_t;

endpackage

// File: rtl/sync_mrx_insync.sv
module sync_mrx_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sync_mrx_baud.sv
module sync_mrx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div16,
   input  logic [DIV_W-1:0] div_full,
   output logic             tick,
   output logic [1:0]       quarter
);
   localparam int HALF_W = DIV_W / 2;

   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] cnt;
   logic [1:0]       q_r;

   assign div_eff = div16 ? div_full : {{(DIV_W-HALF_W){1'b0}}, div_full[HALF_W-1:0]};
   assign tick    = run && (cnt == div_eff);
   assign quarter = q_r;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         q_r <= 2'd0;
      end else if (cnt == div_eff) begin
         cnt <= '0;
         q_r <= q_r + 2'd1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sync_mrx_shift.sv
module sync_mrx_shift #(
   parameter int WORD_W = 9,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [1:0]        quarter,
   input  logic              nine,
   input  logic              rx_s,
   output logic              sclk,
   output logic              word_done,
   output logic [WORD_W-1:0] word
);
   logic [CNT_W-1:0]  bitcnt;
   logic [CNT_W-1:0]  last_idx;
   logic [WORD_W-1:0] sr;
   logic [WORD_W-1:0] next_word;
   logic              rise, fall;

   assign last_idx  = nine ? CNT_W'(WORD_W-1) : CNT_W'(WORD_W-2);
   assign rise      = tick && (quarter == 2'd0);
   assign fall      = tick && (quarter == 2'd2);
   assign word_done = fall && (bitcnt == last_idx);
   assign word      = next_word;

   always_comb begin
      next_word         = sr;
      next_word[bitcnt] = rx_s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         sclk   <= 1'b0;
         bitcnt <= '0;
         sr     <= '0;
      end else begin
         if (rise) sclk <= 1'b1;
         if (fall) begin
            sclk <= 1'b0;
            if (word_done) begin
               bitcnt <= '0;
               sr     <= '0;
            end else begin
               bitcnt <= bitcnt + 1'b1;
               sr     <= next_word;
            end
         end
      end
   end
endmodule

// File: rtl/sync_mrx_regs.sv
module sync_mrx_regs
   import sync_mrx_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              word_done,
   input  logic [REG_W:0]    word,
   output ctrl_t             ctrl,
   output logic [2*REG_W-1:0] div_full,
   output logic [REG_W-1:0]  rd_data,
   output logic              done,
   output logic              overrun,
   output logic [REG_W-1:0]  data_q,
   output logic              irq
);
   logic [REG_W-1:0] ctrl_q, div_lo, div_hi;
   logic             ninth_q;
   logic             ctrl_wr, rd_clr, cont_fall, load, ovr_set;

   assign ctrl      = ctrl_t'(ctrl_q[CTRL_BITS-1:0]);
   assign div_full  = {div_hi, div_lo};
   assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
   assign rd_clr    = rd_en && (rd_addr == A_DATA);
   assign cont_fall = ctrl_wr && ctrl_q[CB_CONT] && !wr_data[CB_CONT];
   assign load      = word_done && !overrun && !(done && !rd_clr);
   assign ovr_set   = word_done && !overrun && done && !rd_clr;
   assign irq       = done && ctrl.irq_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         div_lo  <= '0;
         div_hi  <= '0;
         done    <= 1'b0;
         overrun <= 1'b0;
         data_q  <= '0;
         ninth_q <= 1'b0;
      end else begin
         if (ctrl_wr)
            ctrl_q <= wr_data;
         else if (word_done && !ctrl_q[CB_CONT])
            ctrl_q[CB_SINGLE] <= 1'b0;
         if (wr_en && wr_addr == A_DIV_LO) div_lo <= wr_data;
         if (wr_en && wr_addr == A_DIV_HI) div_hi <= wr_data;

         if (load) begin
            done    <= 1'b1;
            data_q  <= word[REG_W-1:0];
            ninth_q <= word[REG_W];
         end else if (rd_clr) begin
            done <= 1'b0;
         end

         if (cont_fall)    overrun <= 1'b0;
         else if (ovr_set) overrun <= 1'b1;
      end
   end

   always_comb begin
      unique case (rd_addr)
         A_CTRL:   rd_data = ctrl_q;
         A_DIV_LO: rd_data = div_lo;
         A_DIV_HI: rd_data = div_hi;
         A_STAT:   rd_data = REG_W'({ninth_q, overrun, done});
         A_DATA:   rd_data = data_q;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
   import sync_mrx_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic              rx_in,
   output logic              sclk_out,
   output logic              irq
);
   localparam int WORD_W = REG_W + 1;
   localparam int DIV_W  = 2 * REG_W;

   generate
      if (REG_W < 8) begin : g_bad_width
         $error("sync_master_rx: REG_W must be at least 8");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("sync_master_rx: SYNC_STAGES above 4 eats into the sample margin");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [DIV_W-1:0]  div_full;
   logic              run, tick, sclk_int, word_done, rx_s;
   logic [1:0]        quarter;
   logic [WORD_W-1:0] word;
   logic              st_done, st_ovr, ctrl_wr;
   logic [REG_W-1:0]  data_q;

   assign run      = ctrl.sync_mode && (ctrl.single || ctrl.cont);
   assign sclk_out = sclk_int ^ ctrl.invert;
   assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);

   sync_mrx_insync #(.STAGES(SYNC_STAGES)) i_insync (
      .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s));

   sync_mrx_baud #(.DIV_W(DIV_W)) i_baud (
      .clk(clk), .rst_n(rst_n), .run(run), .div16(ctrl.div16),
      .div_full(div_full), .tick(tick), .quarter(quarter));

   sync_mrx_shift #(.WORD_W(WORD_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .quarter(quarter),
      .nine(ctrl.nine), .rx_s(rx_s), .sclk(sclk_int),
      .word_done(word_done), .word(word));

   sync_mrx_regs #(.REG_W(REG_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .word_done(word_done), .word(word), .ctrl(ctrl), .div_full(div_full),
      .rd_data(rd_data), .done(st_done), .overrun(st_ovr), .data_q(data_q),
      .irq(irq));
endmodule

// File: rtl/sync_master_rx_chk.sv
module sync_master_rx_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          sclk_int,
   input logic          word_done,
   input logic          single,
   input logic          cont,
   input logic          ctrl_wr,
   input logic          done,
   input logic          overrun,
   input logic [DW-1:0] data_q,
   input logic          sclk_out,
   input logic          invert
);
   // R2: with reception disabled the internal clock settles low
   a_r2_idle_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sclk_int);

   // R8: when idle, the pin shows the programmed idle level
   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (sclk_out == invert));

   // R6: a word only closes on the high-to-low transition of the clock
   a_r6_sample_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> sclk_int);

   // R3: one-shot enable clears itself after its word
   a_r3_single_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && single && !cont && !ctrl_wr) |=> !single);

   // R10: the ready flag rises only when a word completes
   a_r10_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(word_done));

   // R11: while in overrun the held word never changes
   a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && $past(overrun)) |-> $stable(data_q));
endmodule

bind sync_master_rx sync_master_rx_chk #(.DW(REG_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .sclk_int(sclk_int),
   .word_done(word_done), .single(ctrl.single), .cont(ctrl.cont),
   .ctrl_wr(ctrl_wr), .done(st_done), .overrun(st_ovr), .data_q(data_q),
   .sclk_out(sclk_out), .invert(ctrl.invert));

// File: tb/test_sync_master_rx.sv
module test_sync_master_rx;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   // {word[8:0], nine, invert, div16, hi[7:0], lo[7:0]}
   localparam logic [27:0] VECS [0:5] = '{
      {9'h0A5, 1'b0, 1'b0, 1'b0, 8'd0, 8'd3},
      {9'h15A, 1'b1, 1'b0, 1'b0, 8'd0, 8'd4},
      {9'h13C, 1'b0, 1'b1, 1'b0, 8'd5, 8'd3},
      {9'h0F0, 1'b1, 1'b1, 1'b1, 8'd0, 8'd6},
      {9'h101, 1'b1, 1'b0, 1'b1, 8'd1, 8'd0},
      {9'h0FF, 1'b0, 1'b0, 1'b1, 8'd0, 8'd3}
   };

   logic       clk = 0, rst_n = 0;
   logic       wr_en = 0, rd_en = 0, rx_in = 0;
   logic [2:0] wr_addr = 0, rd_addr = 0;
   logic [7:0] wr_data = 0, rd_data;
   logic       sclk_out, irq;

   int  n_tests = 0, n_fail = 0, cyc = 0;
   int  edge_cnt = 0, last_edge = 0, prev_edge = 0, idx = 0;
   logic        tb_inv = 0, prev_sclk = 0;
   logic [63:0] stream = '0;

   sync_master_rx i_sync_master_rx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .rx_in(rx_in), .sclk_out(sclk_out), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   // slave model: on each active edge present the next stream bit
   always @(negedge clk) begin
      cyc++;
      if (sclk_out != prev_sclk && sclk_out != tb_inv) begin
         rx_in     <= stream[idx];
         idx       = (idx + 1) % 64;
         edge_cnt++;
         prev_edge = last_edge;
         last_edge = cyc;
      end
      prev_sclk = sclk_out;
      if (cyc > WATCHDOG) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic clr, output logic [7:0] d);
      @(negedge clk); rd_addr = a; rd_en = clr; #1 d = rd_data;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic wait_irq(input int limit, input string tag);
      int n = 0;
      while (!irq && n < limit) begin @(negedge clk); n++; end
      chk(tag, irq, 1'b1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      idle(4);
      rst_n = 1;
      idle(2);
      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), 1'b0, v);
         chk("R1 reset register", v, 8'h00);
      end
      chk("R1 reset clock", sclk_out, 1'b0);
      chk("R1 reset irq", irq, 1'b0);

      // R2 no clock without synchronous mode
      wr(3'd1, 8'd3);
      edge_cnt = 0;
      wr(3'd0, 8'h04);
      idle(120);
      chk("R2 no edges without sync mode", edge_cnt, 0);
      rd(3'd3, 1'b0, v);
      chk("R2 no word without sync mode", v, 8'h00);
      wr(3'd0, 8'h00);

      // table of single-word receptions
      for (int k = 0; k < 6; k++) begin
         logic [8:0]  w;
         logic        nine, inv, d16;
         logic [15:0] dv;
         int          nb;
         w = VECS[k][27:19]; nine = VECS[k][18]; inv = VECS[k][17]; d16 = VECS[k][16];
         dv = d16 ? VECS[k][15:0] : {8'd0, VECS[k][7:0]};
         nb = nine ? 9 : 8;
         wr(3'd1, VECS[k][7:0]);
         wr(3'd2, VECS[k][15:8]);
         stream = {55'd0, w}; idx = 0; tb_inv = inv;
         edge_cnt = 0;
         wr(3'd0, {1'b0, 1'b1, d16, inv, nine, 1'b0, 1'b1, 1'b1});
         wait_irq(4 * (dv + 1) * 12, "R10 irq after word");
         idle(8 * (dv + 1));
         chk("R3 one edge per bit", edge_cnt, nb);
         chk("R9 clock period", last_edge - prev_edge, 4 * (dv + 1));
         chk("R8 idle level", sclk_out, inv);
         rd(3'd0, 1'b0, v);
         chk("R3 one-shot bit cleared", v[1], 1'b0);
         rd(3'd3, 1'b0, v);
         chk("R7 ninth bit", v[2], nine & w[8]);
         rd(3'd4, 1'b1, v);
         chk("R6 data lsb first", v, w[7:0]);
         rd(3'd3, 1'b0, v);
         chk("R10 read clears ready", v[0], 1'b0);
         chk("R10 irq follows ready", irq, 1'b0);
      end

      // R5 both enables: continuous wins
      wr(3'd1, 8'd3); wr(3'd2, 8'd0); wr(3'd0, 8'h00);
      stream = {48'd0, 8'hC3, 8'h96, 8'h3B}; idx = 0; tb_inv = 0;
      wr(3'd0, 8'h47);
      wait_irq(400, "R5 first word");
      rd(3'd4, 1'b1, v);
      chk("R5 first word data", v, 8'h3B);
      idle(2);
      wait_irq(400, "R5 second word");
      rd(3'd4, 1'b1, v);
      chk("R5 second word data", v, 8'h96);
      rd(3'd0, 1'b0, v);
      chk("R5 one-shot bit kept", v, 8'h47);
      // R4 stop by clearing continuous
      wr(3'd0, 8'h41);
      idle(2);
      edge_cnt = 0;
      idle(200);
      chk("R4 no edges after stop", edge_cnt, 0);
      chk("R4 clock idle after stop", sclk_out, 1'b0);
      rd(3'd4, 1'b1, v);
      wr(3'd0, 8'h00);

      // R11 overrun
      stream = {8'h88, 8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11}; idx = 0;
      wr(3'd0, 8'h45);
      wait_irq(400, "R11 first word");
      idle(3 * 128 + 50);
      rd(3'd3, 1'b0, v);
      chk("R11 overrun and ready", v, 8'h03);
      rd(3'd4, 1'b1, v);
      chk("R11 unread word held", v, 8'h11);
      rd(3'd3, 1'b0, v);
      chk("R11 ready cleared overrun kept", v, 8'h02);
      idle(200);
      rd(3'd3, 1'b0, v);
      chk("R11 words discarded", v, 8'h02);
      wr(3'd0, 8'h41);
      rd(3'd3, 1'b0, v);
      chk("R11 cleared by dropping continuous", v, 8'h00);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule